// File: doc/BRIEF.md
# Stream Cipher Key/IV Load Sequencer

This block controls the start-up and output phases of a word-oriented stream cipher. The cipher has a sixteen-stage, 32-bit-per-stage feedback shift register and a three-register mixing state machine. Both of those datapaths sit outside this block. The sequencer reaches them only through ports.

A caller provides a 128-bit key, a 128-bit IV and a word count, then pulses `start`. The block then runs four phases in order:

- It presents the initial shift-register image derived from key and IV, together with a clear for the mixing state machine.
- It issues 32 initialization steps in which the state-machine output is fed back into the register.
- It issues one warm-up step whose output is thrown away.
- It issues one step per requested keystream word.

During each keystream step the block forms the output word from the state-machine output and shift-register stage 0. Both values are taken before the register advances on that step's clock edge. The block then flags the word as valid. A one-cycle completion pulse ends the run, and the block returns to waiting for a new start.

Top module: `ks_load_sequencer`

## Requirements
- R1: While reset is held and in the first idle cycle after it, `load_o`, `fsm_clear_o`, `step_o`, `init_mode_o`, `z_valid_o` and `done_o` are all 0 and `z_o` is 0.
- R2: A `start` seen in idle causes `load_o` and `fsm_clear_o` to be 1 for exactly the next cycle, with `step_o` and `init_mode_o` 0 in that cycle.
- R3: Key word j is `key_i[32j+31:32j]` and IV word j is `iv_i[32j+31:32j]`, and stage m of the image is `load_image_o[32m+31:32m]`. The upper half of the image, computed from the key/IV present in the load cycle, is: stage 15 = k3^IV0, stage 14 = k2, stage 13 = k1, stage 12 = k0^IV1, stage 11 = ~k3, stage 10 = ~k2^IV2, stage 9 = ~k1^IV3, stage 8 = ~k0.
- R4: The lower half of the image is: stages 7,6,5,4 = k3,k2,k1,k0 and stages 3,2,1,0 = ~k3,~k2,~k1,~k0.
- R5: The load cycle is followed by exactly 32 consecutive cycles with `step_o` = 1 and `init_mode_o` = 1.
- R6: The last initialization cycle is followed by exactly one warm-up cycle with `step_o` = 1, `init_mode_o` = 0 and `z_valid_o` = 0.
- R7: After warm-up, exactly n cycles have `step_o` = 1, `init_mode_o` = 0 and `z_valid_o` = 1, where n is `word_count_i` sampled with the accepted `start`. In each of them `z_o` equals `fsm_out_i ^ s0_i` of that same cycle. Outside those cycles `z_o` is 0.
- R8: The cycle after the n-th keystream word has `done_o` = 1 and all step strobes 0. The block is then idle, with all strobes 0, in the following cycle.
- R9: With n = 0, `done_o` comes in the cycle right after the warm-up cycle, and no word is flagged valid.
- R10: `start` asserted while a run is in progress has no effect: the phase lengths and the n of the running sequence are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| key_i | input | 128 | Key, word j at bits 32j+31:32j |
| iv_i | input | 128 | IV, word j at bits 32j+31:32j |
| word_count_i | input | CNT_W | Number of keystream words, sampled at start |
| fsm_out_i | input | 32 | Current mixing state-machine output word |
| s0_i | input | 32 | Current shift-register stage 0 |
| load_o | output | 1 | Load the shift register from load_image_o |
| fsm_clear_o | output | 1 | Clear the three state-machine registers |
| load_image_o | output | 512 | Initial register image, stage m at bits 32m+31:32m |
| step_o | output | 1 | Clock state machine and shift register this cycle |
| init_mode_o | output | 1 | Shift register takes feedback injection this step |
| z_o | output | 32 | Keystream word |
| z_valid_o | output | 1 | z_o holds a keystream word this cycle |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
With the start pulse seen at clock edge E, the load strobe and image appear in the cycle after E. Initialization covers the next 32 cycles, warm-up comes at cycle 34, keystream words occupy cycles 35 to 34+n, and done follows at 35+n. Every strobe is a registered-state decode. The keystream word is combinational from the two datapath inputs in a GEN cycle, so the bench changes those inputs at the falling edge and checks 1 ns later within the same cycle. Each scenario walks the cycles one falling edge at a time and compares the strobes against the phase expected for that exact cycle index. This covers keystream counts of 0, 1 and several words, extreme key patterns, and stray start pulses during a run.

// File: rtl/ks_seq_pkg.sv
package ks_seq_pkg;
    localparam int WORD_W    = 32;
    localparam int KEY_WORDS = 4;
    localparam int STAGES    = 16;
    localparam int KEY_W     = WORD_W * KEY_WORDS;
    localparam int IMAGE_W   = WORD_W * STAGES;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_LOAD   = 3'd1,
        PH_INIT   = 3'd2,
        PH_WARMUP = 3'd3,
        PH_GEN    = 3'd4,
        PH_DONE   = 3'd5
    } phase_e;

    typedef struct packed {
        logic load;
        logic fsm_clear;
        logic step;
        logic init_mode;
        logic z_valid;
        logic done;
    } strobes_t;

    // IV word injected into a stage, or -1 when the stage takes none
    function automatic int iv_slot(input int stage);
        case (stage)
            15:      return 0;
            12:      return 1;
            10:      return 2;
            9:       return 3;
            default: return -1;
        endcase
    endfunction

    // stage groups 0 and 2 hold the complemented key
    function automatic bit group_inverted(input int grp);
        return (grp == 0) || (grp == 2);
    endfunction
endpackage

// File: rtl/ks_image_build.sv
module ks_image_build
    import ks_seq_pkg::*;
(
    input  logic [KEY_W-1:0]   key_i,
    input  logic [KEY_W-1:0]   iv_i,
    output logic [IMAGE_W-1:0] image_o
);
    localparam int GROUPS = STAGES / KEY_WORDS;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        for (genvar j = 0; j < KEY_WORDS; j++) begin : g_word
            localparam int STG  = g * KEY_WORDS + j;
            localparam int IVS  = iv_slot(STG);
            localparam bit INV  = group_inverted(g);
            logic [WORD_W-1:0] kw;
            assign kw = INV ? ~key_i[j*WORD_W +: WORD_W] : key_i[j*WORD_W +: WORD_W];
            if (IVS >= 0) begin : g_iv
                assign image_o[STG*WORD_W +: WORD_W] = kw ^ iv_i[IVS*WORD_W +: WORD_W];
            end else begin : g_plain
                assign image_o[STG*WORD_W +: WORD_W] = kw;
            end
        end
    end
endmodule

// File: rtl/ks_phase_ctrl.sv
module ks_phase_ctrl
    import ks_seq_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int INIT_STEPS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] word_count_i,
    output phase_e           phase_o
);
    localparam int IC_W = (INIT_STEPS > 1) ? $clog2(INIT_STEPS) : 1;
    localparam logic [IC_W-1:0] IC_LAST = IC_W'(INIT_STEPS - 1);

    phase_e           phase_q;
    logic [IC_W-1:0]  init_cnt_q;
    logic [CNT_W-1:0] words_left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q      <= PH_IDLE;
            init_cnt_q   <= '0;
            words_left_q <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: if (start) begin
                    phase_q      <= PH_LOAD;
                    words_left_q <= word_count_i;
                end
                PH_LOAD: begin
                    phase_q    <= PH_INIT;
                    init_cnt_q <= '0;
                end
                PH_INIT: begin
                    if (init_cnt_q == IC_LAST) phase_q <= PH_WARMUP;
                    else                       init_cnt_q <= init_cnt_q + 1'b1;
                end
                PH_WARMUP: phase_q <= (words_left_q == '0) ? PH_DONE : PH_GEN;
                PH_GEN: begin
                    if (words_left_q == CNT_W'(1)) phase_q <= PH_DONE;
                    words_left_q <= words_left_q - 1'b1;
                end
                PH_DONE: phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase_o = phase_q;
endmodule

// File: rtl/ks_strobe_decode.sv
module ks_strobe_decode
    import ks_seq_pkg::*;
(
    input  phase_e            phase_i,
    input  logic [WORD_W-1:0] fsm_out_i,
    input  logic [WORD_W-1:0] s0_i,
    output strobes_t          strb_o,
    output logic [WORD_W-1:0] z_o
);
    always_comb begin
        strb_o = '0;
        case (phase_i)
            PH_LOAD:   begin strb_o.load = 1'b1; strb_o.fsm_clear = 1'b1; end
            PH_INIT:   begin strb_o.step = 1'b1; strb_o.init_mode = 1'b1; end
            PH_WARMUP: strb_o.step = 1'b1;
            PH_GEN:    begin strb_o.step = 1'b1; strb_o.z_valid = 1'b1; end
            PH_DONE:   strb_o.done = 1'b1;
            default:   strb_o = '0;
        endcase
    end

    // word is taken from pre-shift values of the same cycle
    assign z_o = (phase_i == PH_GEN) ? (fsm_out_i ^ s0_i) : '0;
endmodule

// File: rtl/ks_load_sequencer.sv
module ks_load_sequencer
    import ks_seq_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int INIT_STEPS = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [KEY_W-1:0]   key_i,
    input  logic [KEY_W-1:0]   iv_i,
    input  logic [CNT_W-1:0]   word_count_i,
    input  logic [WORD_W-1:0]  fsm_out_i,
    input  logic [WORD_W-1:0]  s0_i,
    output logic               load_o,
    output logic               fsm_clear_o,
    output logic [IMAGE_W-1:0] load_image_o,
    output logic               step_o,
    output logic               init_mode_o,
    output logic [WORD_W-1:0]  z_o,
    output logic               z_valid_o,
    output logic               done_o
);
    phase_e   phase;
    strobes_t strb;

    ks_image_build u_image (
        .key_i   (key_i),
        .iv_i    (iv_i),
        .image_o (load_image_o)
    );

    ks_phase_ctrl #(.CNT_W(CNT_W), .INIT_STEPS(INIT_STEPS)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .word_count_i (word_count_i),
        .phase_o      (phase)
    );

    ks_strobe_decode u_dec (
        .phase_i   (phase),
        .fsm_out_i (fsm_out_i),
        .s0_i      (s0_i),
        .strb_o    (strb),
        .z_o       (z_o)
    );

    assign load_o      = strb.load;
    assign fsm_clear_o = strb.fsm_clear;
    assign step_o      = strb.step;
    assign init_mode_o = strb.init_mode;
    assign z_valid_o   = strb.z_valid;
    assign done_o      = strb.done;
endmodule

// File: rtl/ks_load_sequencer_chk.sv
module ks_load_sequencer_chk #(
    parameter int INIT_STEPS = 32
) (
    input logic clk,
    input logic rst,
    input logic load_o,
    input logic fsm_clear_o,
    input logic step_o,
    input logic init_mode_o,
    input logic z_valid_o,
    input logic done_o
);
    logic [15:0] init_run_q;

    always_ff @(posedge clk) begin
        if (rst || load_o) init_run_q <= '0;
        else if (init_mode_o) init_run_q <= init_run_q + 1'b1;
    end

    // R2
    load_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        load_o |-> fsm_clear_o && !step_o ##1 !load_o);

    // R5
    init_entry_chk: assert property (@(posedge clk) disable iff (rst)
        load_o |=> step_o && init_mode_o);

    // R5
    init_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(init_mode_o) |-> init_run_q == 16'(INIT_STEPS));

    // R6
    warmup_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(init_mode_o) |-> step_o && !z_valid_o);

    // R7
    gen_mode_chk: assert property (@(posedge clk) disable iff (rst)
        z_valid_o |-> step_o && !init_mode_o);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !step_o ##1 !done_o && !step_o && !load_o);

    // R8
    excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({load_o, z_valid_o, done_o}));
endmodule

bind ks_load_sequencer ks_load_sequencer_chk #(.INIT_STEPS(INIT_STEPS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .load_o      (load_o),
    .fsm_clear_o (fsm_clear_o),
    .step_o      (step_o),
    .init_mode_o (init_mode_o),
    .z_valid_o   (z_valid_o),
    .done_o      (done_o)
);

// File: tb/test_ks_load_sequencer.sv
module test_ks_load_sequencer;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [127:0] key = '0;
    logic [127:0] iv = '0;
    logic [15:0]  wcount = '0;
    logic [31:0]  fo = '0;
    logic [31:0]  s0 = '0;
    logic         load_o, fsm_clear_o, step_o, init_mode_o, z_valid_o, done_o;
    logic [511:0] image;
    logic [31:0]  z_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    ks_load_sequencer i_ks_load_sequencer (
        .clk(clk), .rst(rst), .start(start), .key_i(key), .iv_i(iv),
        .word_count_i(wcount), .fsm_out_i(fo), .s0_i(s0),
        .load_o(load_o), .fsm_clear_o(fsm_clear_o), .load_image_o(image),
        .step_o(step_o), .init_mode_o(init_mode_o), .z_o(z_o),
        .z_valid_o(z_valid_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [5:0] strobes();
        return {load_o, fsm_clear_o, step_o, init_mode_o, z_valid_o, done_o};
    endfunction

    task automatic chk_strobes(input logic [5:0] exp, input string req);
        chk(strobes() === exp, req, 32'(strobes()), 32'(exp));
    endtask

    function automatic logic [31:0] kw(input int j); return key[32*j +: 32]; endfunction
    function automatic logic [31:0] ivw(input int j); return iv[32*j +: 32]; endfunction
    function automatic logic [31:0] stg(input int m); return image[32*m +: 32]; endfunction

    task automatic chk_image();
        chk(stg(15) === (kw(3) ^ ivw(0)), "R3 s15", stg(15), kw(3) ^ ivw(0));
        chk(stg(14) === kw(2), "R3 s14", stg(14), kw(2));
        chk(stg(13) === kw(1), "R3 s13", stg(13), kw(1));
        chk(stg(12) === (kw(0) ^ ivw(1)), "R3 s12", stg(12), kw(0) ^ ivw(1));
        chk(stg(11) === ~kw(3), "R3 s11", stg(11), ~kw(3));
        chk(stg(10) === (~kw(2) ^ ivw(2)), "R3 s10", stg(10), ~kw(2) ^ ivw(2));
        chk(stg(9)  === (~kw(1) ^ ivw(3)), "R3 s9", stg(9), ~kw(1) ^ ivw(3));
        chk(stg(8)  === ~kw(0), "R3 s8", stg(8), ~kw(0));
        for (int j = 0; j < 4; j++) begin
            chk(stg(4 + j) === kw(j), "R4 plain", stg(4 + j), kw(j));
            chk(stg(j) === ~kw(j), "R4 inverted", stg(j), ~kw(j));
        end
    endtask

    // full run: spam drives start high during initialization (R10)
    task automatic run_seq(input logic [127:0] k, input logic [127:0] v, input int n, input bit spam);
        @(negedge clk);
        key = k; iv = v; wcount = 16'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (spam) wcount = 16'(n + 5);
        #1;
        chk_strobes(6'b110000, "R2 load cycle");
        chk_image();
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            start = spam && (i % 3 == 0);
            #1;
            chk_strobes(6'b001100, spam ? "R10 init under start" : "R5 init step");
            chk(z_o === 32'h0, "R7 z idle", z_o, 32'h0);
        end
        @(negedge clk);
        start = 1'b0;
        #1;
        chk_strobes(6'b001000, "R6 warm-up");
        for (int w = 0; w < n; w++) begin
            @(negedge clk);
            fo = $urandom; s0 = $urandom;
            #1;
            chk_strobes(6'b001010, spam ? "R10 gen count" : "R7 gen step");
            chk(z_o === (fo ^ s0), "R7 word", z_o, fo ^ s0);
        end
        @(negedge clk);
        #1;
        chk_strobes(6'b000001, n == 0 ? "R9 done after warm-up" : "R8 done");
        @(negedge clk);
        #1;
        chk_strobes(6'b000000, "R8 idle after done");
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk_strobes(6'b000000, "R1 in reset");
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk_strobes(6'b000000, "R1 after reset");
        chk(z_o === 32'h0, "R1 z", z_o, 32'h0);
    endtask

    task automatic test_several_words();
        run_seq({32'h33333333, 32'h22222222, 32'h11111111, 32'h00000000},
                {32'hDDDDDDDD, 32'hCCCCCCCC, 32'hBBBBBBBB, 32'hAAAAAAAA}, 4, 1'b0);
    endtask

    task automatic test_zero_words();
        run_seq({4{32'hFFFFFFFF}}, '0, 0, 1'b0);
    endtask

    task automatic test_one_word();
        run_seq('0, {4{32'hFFFFFFFF}}, 1, 1'b0);
    endtask

    task automatic test_start_ignored();
        run_seq({32'h01234567, 32'h89ABCDEF, 32'hFEDCBA98, 32'h76543210},
                {32'h0F1E2D3C, 32'h4B5A6978, 32'h8796A5B4, 32'hC3D2E1F0}, 3, 1'b1);
    endtask

    initial begin
        test_reset();
        test_several_words();
        test_zero_words();
        test_one_word();
        test_start_ignored();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule